// File: doc/BRIEF.md
# Dual Interval Timer

This block holds two 16-bit down-counting interval timers behind a byte-wide register window. A host reads and writes it one byte at a time. Every cycle in which the tick-enable input is high, each running counter loses one. A counter that reaches zero raises its own interrupt flag, and both flags leave the block as level outputs for a shared interrupt controller. The tick-enable input lets an external prescaler slow both timers down.

The first timer keeps a 16-bit reload latch apart from its counter. Writes to the latch only stage a value. A write to the counter's upper-byte address copies the whole latch into the counter and starts the timer. One control bit selects what happens on expiry: the timer stops (one-shot), or it reloads from the latch and keeps going (continuous). The second timer is one-shot only. Writing its low byte loads the count and stops the timer. Writing its high byte adds that byte into the upper half of the count and starts it.

Top module: `itmr_dual_timer`

## Requirements
- R1: After synchronous reset, both counters, the latch, the control bit and both flags are zero, both timers are stopped, and every register reads as zero.
- R2: A write to offset 2 sets only latch bits 7:0 and does not start the first timer. A write to offset 3 sets latch bits 15:8 and clears the first timer's flag. Both latch bytes read back at the offset they were written to.
- R3: A write to offset 1 copies the full latch into the first counter, starts the first timer and clears its flag. The written data byte is ignored.
- R4: A running counter decrements by one on each clock cycle with `tick_en` high. A counter holds its value when `tick_en` is low or when the timer is stopped.
- R5: On the tick that takes a running counter from 1 to zero, or on any tick while it already holds zero, the flag is set in that same cycle. A one-shot timer then stops with its count at zero. A count of N therefore expires on its Nth tick.
- R6: Control register bit 0 (offset 6) selects continuous mode for the first timer. In continuous mode the timer reloads from the latch on each expiry, stays running, and sets its flag on every expiry. Writing the control register with bit 0 set starts the first timer without changing its count.
- R7: A read of offset 0 returns first-counter bits 7:0 and clears the first timer's flag. Reads of offsets 1, 2, 3, 5, 6 and 7 have no side effect.
- R8: A write to offset 4 loads the byte, zero-extended, into the second counter, stops the second timer and clears its flag.
- R9: A write to offset 5 adds the byte, shifted up by 8 bits, into the second counter, starts the second timer and clears its flag. The second timer always stops at expiry, whatever the control bit says.
- R10: A read of offset 4 returns second-counter bits 7:0 and clears the second timer's flag. Offset 5 reads bits 15:8.
- R11: When an expiry falls in the same cycle as a flag-clearing read (offset 0) or a latch-high write (offset 3), the flag ends up set.
- R12: Read data appears on `bus_rdata` on the cycle after the read access. Offset 7 reads the first timer's flag in bit 0 and the second timer's flag in bit 1. `irq_t1` and `irq_t2` carry those same flags.
- R13: Addresses with any bit above bit 2 set read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for both timers, one decrement per high cycle |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | High for a write access, low for a read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | DATA_W | Write data byte |
| bus_rdata | output | DATA_W | Registered read data, valid one cycle after the read |
| irq_t1 | output | 1 | First timer expiry flag |
| irq_t2 | output | 1 | Second timer expiry flag |

## Verification
The bench uses the default parameters: an 8-bit data path, a 16-bit count and a 4-bit address. The 4-bit address leaves an upper half of the space that aliases the eight real offsets in its low bits. Writes there reach the decoder, so the bench can show that they are ignored. The 16-bit count lets the second timer start at 0x0103, so the run borrows across the byte boundary before it expires. The table and the directed tests land expiries in the same cycle as clearing reads and writes, and they check that the second timer stays one-shot while continuous mode is selected.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  // Number of address bits that select one of the eight registers
  localparam int unsigned REG_BITS = 3;

  // Register offsets inside the window
  typedef enum logic [REG_BITS-1:0] {
    REG_T1_CLO = 3'd0,  // first counter low byte (read clears flag 1)
    REG_T1_CHI = 3'd1,  // first counter high byte (write loads + starts)
    REG_T1_LLO = 3'd2,  // reload latch low byte
    REG_T1_LHI = 3'd3,  // reload latch high byte (write clears flag 1)
    REG_T2_LO  = 3'd4,  // second counter low byte
    REG_T2_HI  = 3'd5,  // second counter high byte
    REG_CTRL   = 3'd6,  // bit 0: continuous mode for the first timer
    REG_STAT   = 3'd7   // bit 0: flag 1, bit 1: flag 2
  } itmr_reg_e;

  // One-cycle access strobes from the decoder
  typedef struct packed {
    logic t1_chi_wr;
    logic t1_lhi_wr;
    logic t1_clo_rd;
    logic t2_lo_wr;
    logic t2_hi_wr;
    logic t2_lo_rd;
    logic ctrl_wr;
  } itmr_strobe_t;

endpackage

// File: rtl/itmr_engine.sv
// One down-counter with start/stop state and a sticky expiry flag.
// RELOAD_EN selects whether the continuous-reload variant is built.
module itmr_engine #(
  parameter int unsigned CNT_W     = 16,
  parameter bit          RELOAD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             start,
  input  logic             halt,
  input  logic             cont,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             clr,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             flag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic cont_eff;
  logic [CNT_W-1:0] reload_eff;

  generate
    if (RELOAD_EN) begin : g_reload
      assign cont_eff   = cont;
      assign reload_eff = reload_val;
    end else begin : g_oneshot
      logic unused_reload;
      assign unused_reload = ^{cont, reload_val};
      assign cont_eff      = 1'b0;
      assign reload_eff    = '0;
    end
  endgenerate

  // A bus load overrides counting in its cycle, so no expiry then
  logic expire;
  assign expire = !load && run && tick && (count <= ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (run && tick) begin
      if (count <= ONE) count <= cont_eff ? reload_eff : '0;
      else              count <= count - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
    end else if (halt) begin
      run <= 1'b0;
    end else if (start) begin
      run <= 1'b1;
    end else if (expire && !cont_eff) begin
      run <= 1'b0;
    end
  end

  // Expiry has priority over a clearing access in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
    end else if (expire) begin
      flag <= 1'b1;
    end else if (clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/itmr_regs.sv
// Address decode, reload latch, control bit and registered read mux.
module itmr_regs
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  t1_count,
  input  logic [CNT_W-1:0]  t2_count,
  input  logic              t1_flag,
  input  logic              t2_flag,
  output itmr_strobe_t      strb,
  output logic [CNT_W-1:0]  t1_latch,
  output logic              t1_cont,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned NBYTES = CNT_W / DATA_W;

  logic      in_map, wr_hit, rd_hit;
  itmr_reg_e reg_id;

  // Full decode: any upper address bit set leaves the window
  assign in_map = bus_sel && (bus_addr[ADDR_W-1:REG_BITS] == '0);
  assign reg_id = itmr_reg_e'(bus_addr[REG_BITS-1:0]);
  assign wr_hit = in_map && bus_wr;
  assign rd_hit = in_map && !bus_wr;

  always_comb begin
    strb           = '0;
    strb.t1_chi_wr = wr_hit && (reg_id == REG_T1_CHI);
    strb.t1_lhi_wr = wr_hit && (reg_id == REG_T1_LHI);
    strb.t1_clo_rd = rd_hit && (reg_id == REG_T1_CLO);
    strb.t2_lo_wr  = wr_hit && (reg_id == REG_T2_LO);
    strb.t2_hi_wr  = wr_hit && (reg_id == REG_T2_HI);
    strb.t2_lo_rd  = rd_hit && (reg_id == REG_T2_LO);
    strb.ctrl_wr   = wr_hit && (reg_id == REG_CTRL);
  end

  // Reload latch, one byte lane per latch address
  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_latch
      logic lane_wr;
      if (b == 0) begin : g_lo
        assign lane_wr = wr_hit && (reg_id == REG_T1_LLO);
      end else begin : g_hi
        assign lane_wr = wr_hit && (reg_id == REG_T1_LHI);
      end
      always_ff @(posedge clk) begin
        if (rst)          t1_latch[b*DATA_W +: DATA_W] <= '0;
        else if (lane_wr) t1_latch[b*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)               t1_cont <= 1'b0;
    else if (strb.ctrl_wr) t1_cont <= bus_wdata[0];
  end

  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    unique case (reg_id)
      REG_T1_CLO: rd_mux = t1_count[DATA_W-1:0];
      REG_T1_CHI: rd_mux = t1_count[CNT_W-1:DATA_W];
      REG_T1_LLO: rd_mux = t1_latch[DATA_W-1:0];
      REG_T1_LHI: rd_mux = t1_latch[CNT_W-1:DATA_W];
      REG_T2_LO:  rd_mux = t2_count[DATA_W-1:0];
      REG_T2_HI:  rd_mux = t2_count[CNT_W-1:DATA_W];
      REG_CTRL:   rd_mux = DATA_W'(t1_cont);
      REG_STAT:   rd_mux = DATA_W'({t2_flag, t1_flag});
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_hit ? rd_mux : '0;
  end

endmodule

// File: rtl/itmr_dual_timer.sv
module itmr_dual_timer
  import itmr_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_t1,
  output logic              irq_t2
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  itmr_strobe_t     strb;
  logic [CNT_W-1:0] t1_latch, t1_count, t2_count, t2_load_val;
  logic             t1_cont, t1_run, t2_run, t1_flag, t2_flag;

  itmr_regs #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .t1_count (t1_count),
    .t2_count (t2_count),
    .t1_flag  (t1_flag),
    .t2_flag  (t2_flag),
    .strb     (strb),
    .t1_latch (t1_latch),
    .t1_cont  (t1_cont),
    .bus_rdata(bus_rdata)
  );

  // First timer: counter-high write copies the latch in; the control
  // write with the continuous bit set restarts without a reload.
  itmr_engine #(
    .CNT_W    (CNT_W),
    .RELOAD_EN(1'b1)
  ) i_t1 (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .load      (strb.t1_chi_wr),
    .load_val  (t1_latch),
    .start     (strb.t1_chi_wr || (strb.ctrl_wr && bus_wdata[0])),
    .halt      (1'b0),
    .cont      (t1_cont),
    .reload_val(t1_latch),
    .clr       (strb.t1_chi_wr || strb.t1_lhi_wr || strb.t1_clo_rd),
    .count     (t1_count),
    .run       (t1_run),
    .flag      (t1_flag)
  );

  // Second timer: low write replaces the count, high write adds the
  // byte into the upper half.
  assign t2_load_val = strb.t2_lo_wr ? CNT_W'(bus_wdata)
                                     : t2_count + {bus_wdata, {DATA_W{1'b0}}};

  itmr_engine #(
    .CNT_W    (CNT_W),
    .RELOAD_EN(1'b0)
  ) i_t2 (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_en),
    .load      (strb.t2_lo_wr || strb.t2_hi_wr),
    .load_val  (t2_load_val),
    .start     (strb.t2_hi_wr),
    .halt      (strb.t2_lo_wr),
    .cont      (1'b0),
    .reload_val('0),
    .clr       (strb.t2_lo_wr || strb.t2_hi_wr || strb.t2_lo_rd),
    .count     (t2_count),
    .run       (t2_run),
    .flag      (t2_flag)
  );

  assign irq_t1 = t1_flag;
  assign irq_t2 = t2_flag;

endmodule

// File: rtl/itmr_checker.sv
module itmr_checker #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_t1,
  input logic              irq_t2,
  input logic [CNT_W-1:0]  t1_count,
  input logic [CNT_W-1:0]  t2_count,
  input logic              t1_run,
  input logic              t2_run,
  input logic              t1_cont
);

  logic wr_t1chi, wr_t2lo, wr_t2hi;
  assign wr_t1chi = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));
  assign wr_t2lo  = bus_sel && bus_wr && (bus_addr == ADDR_W'(4));
  assign wr_t2hi  = bus_sel && bus_wr && (bus_addr == ADDR_W'(5));

  a_r3_load_starts: assert property (@(posedge clk) disable iff (rst)
    wr_t1chi |=> (t1_run && !irq_t1));

  a_r8_low_write_halts: assert property (@(posedge clk) disable iff (rst)
    wr_t2lo |=> (!t2_run && !irq_t2));

  a_r9_high_write_starts: assert property (@(posedge clk) disable iff (rst)
    wr_t2hi |=> (t2_run && !irq_t2));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !bus_sel) |=> ($stable(t1_count) && $stable(t2_count)));

  a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
    (t2_run && tick_en && !bus_sel && (t2_count > CNT_W'(1)))
      |=> (t2_count == $past(t2_count) - CNT_W'(1)));

  a_r5_oneshot_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_t2) |-> (t2_count == '0 && !t2_run));

  a_r6_keeps_running: assert property (@(posedge clk) disable iff (rst)
    (t1_cont && t1_run && tick_en && !bus_sel) |=> t1_run);

endmodule

bind itmr_dual_timer itmr_checker #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .irq_t1  (irq_t1),
  .irq_t2  (irq_t2),
  .t1_count(t1_count),
  .t2_count(t2_count),
  .t1_run  (t1_run),
  .t2_run  (t2_run),
  .t1_cont (t1_cont)
);

// File: tb/test_itmr_dual_timer.sv
`timescale 1ns/1ps
module test_itmr_dual_timer;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [1:0] OW = 2'd1;  // write
  localparam logic [1:0] OR = 2'd2;  // read and compare
  localparam logic [1:0] OT = 2'd3;  // data = number of tick cycles

  // {op, addr, data, expected read}
  localparam int NV = 84;
  localparam logic [21:0] VEC [NV] = '{
    // R2 latch staging
    {OW,4'h2,8'h05,8'h00}, {OW,4'h3,8'h00,8'h00}, {OR,4'h2,8'h00,8'h05},
    {OR,4'h3,8'h00,8'h00}, {OR,4'h1,8'h00,8'h00}, {OR,4'h0,8'h00,8'h00},
    {OT,4'h0,8'd3,8'h00},  {OR,4'h0,8'h00,8'h00},
    // R3 load from latch
    {OW,4'h1,8'hAA,8'h00}, {OR,4'h0,8'h00,8'h05}, {OR,4'h1,8'h00,8'h00},
    // R4 decrement
    {OT,4'h0,8'd3,8'h00},  {OR,4'h0,8'h00,8'h02},
    // R5 one-shot expiry, R7 clearing read
    {OT,4'h0,8'd2,8'h00},  {OR,4'h7,8'h00,8'h01}, {OR,4'h0,8'h00,8'h00},
    {OR,4'h7,8'h00,8'h00}, {OT,4'h0,8'd3,8'h00},  {OR,4'h7,8'h00,8'h00},
    {OR,4'h0,8'h00,8'h00},
    // R9 R10 second timer across the byte borrow
    {OW,4'h4,8'h03,8'h00}, {OW,4'h5,8'h01,8'h00}, {OR,4'h5,8'h00,8'h01},
    {OR,4'h4,8'h00,8'h03}, {OT,4'h0,8'd200,8'h00},{OT,4'h0,8'd58,8'h00},
    {OR,4'h4,8'h00,8'h01}, {OR,4'h7,8'h00,8'h00}, {OT,4'h0,8'd1,8'h00},
    {OR,4'h7,8'h00,8'h02}, {OR,4'h5,8'h00,8'h00}, {OR,4'h7,8'h00,8'h02},
    {OR,4'h4,8'h00,8'h00}, {OR,4'h7,8'h00,8'h00},
    // R6 continuous reload
    {OW,4'h2,8'h04,8'h00}, {OW,4'h3,8'h00,8'h00}, {OW,4'h1,8'h00,8'h00},
    {OW,4'h6,8'h01,8'h00}, {OR,4'h6,8'h00,8'h01}, {OT,4'h0,8'd4,8'h00},
    {OR,4'h7,8'h00,8'h01}, {OR,4'h0,8'h00,8'h04}, {OR,4'h7,8'h00,8'h00},
    {OT,4'h0,8'd2,8'h00},  {OR,4'h0,8'h00,8'h02}, {OT,4'h0,8'd2,8'h00},
    {OR,4'h7,8'h00,8'h01}, {OR,4'h0,8'h00,8'h04}, {OW,4'h6,8'h00,8'h00},
    {OT,4'h0,8'd4,8'h00},  {OR,4'h7,8'h00,8'h01}, {OR,4'h0,8'h00,8'h00},
    {OT,4'h0,8'd2,8'h00},  {OR,4'h0,8'h00,8'h00}, {OR,4'h7,8'h00,8'h00},
    // R6 control write starts a stopped timer
    {OW,4'h6,8'h01,8'h00}, {OT,4'h0,8'd1,8'h00},  {OR,4'h7,8'h00,8'h01},
    {OR,4'h0,8'h00,8'h04}, {OW,4'h6,8'h00,8'h00}, {OT,4'h0,8'd4,8'h00},
    {OR,4'h0,8'h00,8'h00}, {OR,4'h7,8'h00,8'h00},
    // R13 out-of-window accesses
    {OW,4'h9,8'hFF,8'h00}, {OR,4'h9,8'h00,8'h00}, {OW,4'hF,8'h12,8'h00},
    {OR,4'hF,8'h00,8'h00}, {OR,4'h7,8'h00,8'h00}, {OW,4'hA,8'h77,8'h00},
    {OR,4'h2,8'h00,8'h04}, {OR,4'hA,8'h00,8'h00},
    // R8 low write halts
    {OW,4'h4,8'h05,8'h00}, {OW,4'h5,8'h00,8'h00}, {OT,4'h0,8'd2,8'h00},
    {OR,4'h4,8'h00,8'h03}, {OW,4'h4,8'h07,8'h00}, {OT,4'h0,8'd3,8'h00},
    {OR,4'h4,8'h00,8'h07}, {OR,4'h7,8'h00,8'h00},
    // R9 high write adds
    {OW,4'h5,8'h02,8'h00}, {OR,4'h5,8'h00,8'h02}, {OR,4'h4,8'h00,8'h07},
    {OW,4'h4,8'h00,8'h00}, {OR,4'h7,8'h00,8'h00}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq_t1, irq_t2;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  itmr_dual_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_itmr_dual_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_t1(irq_t1), .irq_t2(irq_t2)
  );

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic tk);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic tk, input int req, input logic [7:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; tick_en = tk;
    @(negedge clk);
    bus_sel = 1'b0; tick_en = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, {6'b0, irq_t2, irq_t1}, 8'h00);
    for (int a = 0; a < 8; a++) rd(4'(a), 1'b0, 1, 8'h00);

    // Table walk (R2 to R10, R13; R12 timing is exercised by every read)
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][21:20])
        OW: wr(VEC[i][19:16], VEC[i][15:8], 1'b0);
        OR: rd(VEC[i][19:16], 1'b0, 12, VEC[i][7:0]);
        OT: ticks(int'(VEC[i][15:8]));
        default: ;
      endcase
    end

    // R11 expiry coinciding with a clearing read
    wr(4'h2, 8'h02, 1'b0); wr(4'h3, 8'h00, 1'b0); wr(4'h1, 8'h00, 1'b0);
    ticks(1);
    rd(4'h0, 1'b1, 11, 8'h01);
    check(11, {7'b0, irq_t1}, 8'h01);
    rd(4'h0, 1'b0, 7, 8'h00);
    check(7, {7'b0, irq_t1}, 8'h00);
    // R11 expiry coinciding with a latch-high write
    wr(4'h1, 8'h00, 1'b0);
    ticks(1);
    wr(4'h3, 8'h00, 1'b1);
    check(11, {7'b0, irq_t1}, 8'h01);
    // R2 latch-high write clears the flag
    wr(4'h3, 8'h00, 1'b0);
    check(2, {7'b0, irq_t1}, 8'h00);

    // R9 second timer stays one-shot in continuous mode
    wr(4'h6, 8'h01, 1'b0);
    wr(4'h4, 8'h02, 1'b0); wr(4'h5, 8'h00, 1'b0);
    ticks(2);
    check(5, {7'b0, irq_t2}, 8'h01);
    ticks(3);
    rd(4'h4, 1'b0, 9, 8'h00);
    ticks(2);
    check(9, {7'b0, irq_t2}, 8'h00);
    wr(4'h6, 8'h00, 1'b0);
    // R9 high write clears a pending flag
    wr(4'h4, 8'h01, 1'b0); wr(4'h5, 8'h00, 1'b0);
    ticks(1);
    check(12, {7'b0, irq_t2}, 8'h01);
    wr(4'h5, 8'h00, 1'b0);
    check(9, {7'b0, irq_t2}, 8'h00);
    wr(4'h4, 8'h00, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule